// File: doc/BRIEF.md
# Cascaded Delta-Sigma Fraction Modulator

This block produces the fractional part of a fractional-N divide ratio. Once per comparison-clock cycle it emits a small signed offset, which the divider adds to its integer modulus. The long-run mean of that offset equals the programmed fraction. The fraction comes from an 18-bit word `frac_k` and a dither bit `lsb_dither_en`. Together they form a 19-bit accumulator input of 2K plus the dither bit, so the step size is one part in 2^19 and a set dither bit adds a bias of exactly one such part. The loop may be a cascade of two first-order accumulators (second-order shaping) or of three (third-order shaping), chosen by `order_sel`.

Each accumulator stage adds its input to its own 19-bit register. Bit 19 of that sum is the stage carry. The first stage adds the input word. Every later stage adds the freshly updated register value of the stage before it. The carries are then combined through digital differentiators into the offset, which is registered.

The block falls back to plain integer division when `int_force` is high or when `frac_k` is zero. In that state the offset is held at zero, the `int_mode` flag is raised, and all accumulator and history state is wiped. When modulation resumes, it starts from a known zero state.

Top module: `mash_frac_mod`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `offset` to 0 and `int_mode` to 1, and clears every accumulator and carry history register.
- R2: The accumulator input word is the 19-bit value x = 2*frac_k + lsb_dither_en. Stage 1 adds x to its 19-bit register. Stage 2 adds the new stage-1 register value. Stage 3 adds the new stage-2 register value. A stage's carry c is bit 19 of its 20-bit sum, and its register keeps the low 19 bits.
- R3: With `order_sel` = 0 (second order), the offset after an edge is c1 + c2 - c2', where c2' is stage 2's carry from the previous operating edge. It lies in -1..+2.
- R4: With `order_sel` = 1 (third order), the term c3 - 2*c3' + c3'' is added to the R3 value, where c3' and c3'' are stage 3's carries from one and two edges earlier. The offset lies in -3..+4.
- R5: If `int_force` is 1 at an edge, then after that edge `offset` is 0 and `int_mode` is 1, whatever the other inputs are.
- R6: If `frac_k` is 0 at an edge, the result is the same as R5, even with `int_force` at 0 and `lsb_dither_en` at 1.
- R7: An edge in integer mode clears all three accumulators and the c2', c3', c3'' history. The first operating edge after it therefore starts from zero state.
- R8: After T operating edges with a constant word x, counted from a clearing edge, the running sum S of offsets meets the following bounds, where F = floor(T*x/2^19). In second order, S - F is 0 or 1. In third order, S - F lies in -1..+2. Over a full 2^19-edge window the mean offset is therefore x/2^19.
- R9: `offset` and `int_mode` are registered. They reflect the inputs sampled at the most recent rising edge and are stable between edges. An operating edge drives `int_mode` to 0.
- R10: Changing `order_sel` while modulation runs does not clear the accumulators or the carry history. The next offset follows R3 or R4 using the carried state.
- R11: `offset` is a 4-bit two's-complement number; for example, -1 is 4'b1111 and +4 is 4'b0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Comparison-frequency clock |
| rst | input | 1 | Synchronous reset, active high |
| frac_k | input | 18 | Fractional word K; 0 selects integer mode |
| lsb_dither_en | input | 1 | Sets the 19th (lowest) accumulator input bit |
| order_sel | input | 1 | 0 = two-stage cascade, 1 = three-stage cascade |
| int_force | input | 1 | Forces integer mode when high |
| offset | output | 4 | Signed divide-ratio offset, two's complement |
| int_mode | output | 1 | High while the modulator is bypassed |

## Verification
A corrupted accumulator, a lost carry or a stale differentiator register shows at `offset` no later than the edge that first uses it. Carries propagate combinationally through all three stages, and the output is registered once. For this reason the bench keeps its own cycle-exact model of the cascade and compares every edge. Slow errors, such as a dropped dither bit or a wrong input word, may not alter a single sample for thousands of cycles. Those are caught instead by the running-sum bound of R8 over long constant-word runs. Clearing faults appear on the first edge after integer mode, where the offset must start from zero state.

// File: rtl/mash_pkg.sv
`timescale 1ns/1ps
package mash_pkg;

    // Number of first-order accumulator stages in the longest cascade.
    localparam int STAGES = 3;

    // Noise-shaping order select encoding.
    typedef enum logic {
        ORDER_2 = 1'b0,
        ORDER_3 = 1'b1
    } shape_order_e;

endpackage

// File: rtl/mash_word_ctrl.sv
`timescale 1ns/1ps
module mash_word_ctrl #(
    parameter int KW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [KW-1:0] frac_k,
    input  logic          dither_en,
    input  logic          int_force,
    output logic [KW:0]   word,
    output logic          int_now,
    output logic          int_flag
);

    typedef struct packed {
        logic flag;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    // Integer mode is requested explicitly or implied by a zero fraction.
    always_comb begin
        int_now = int_force | (frac_k == '0);
        word    = {frac_k, dither_en};
        st_d    = st_q;
        st_d.flag = int_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.flag <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_flag = st_q.flag;

    assert_k0_int_R6: assert property (@(posedge clk) disable iff (rst)
        (frac_k == '0) |=> int_flag);

    assert_force_int_R5: assert property (@(posedge clk) disable iff (rst)
        int_force |=> int_flag);

    assert_run_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (!int_force && frac_k != '0) |=> !int_flag);

endmodule

// File: rtl/mash_acc_stage.sv
`timescale 1ns/1ps
module mash_acc_stage #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] addend,
    output logic [W-1:0] residue,
    output logic         carry
);

    typedef struct packed {
        logic [W-1:0] acc;
    } stage_state_t;

    stage_state_t st_d, st_q;
    logic [W:0]   sum;

    always_comb begin
        sum  = {1'b0, st_q.acc} + {1'b0, addend};
        st_d = st_q;
        if (clr) begin
            st_d.acc = '0;
        end else begin
            st_d.acc = sum[W-1:0];
        end
    end

    // The next stage consumes the updated residue in the same cycle.
    assign residue = st_d.acc;
    assign carry   = ~clr & sum[W];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (st_q.acc == '0));

    assert_carry_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (!clr && carry) |-> (residue < addend));

    assert_no_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (!clr && !carry) |-> (residue >= addend));

endmodule

// File: rtl/mash_noise_combiner.sv
`timescale 1ns/1ps
module mash_noise_combiner
    import mash_pkg::*;
#(
    parameter int OW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              order_sel,
    input  logic [STAGES-1:0] carry,
    output logic [OW-1:0]     offset
);

    localparam int SW = OW + 1;

    typedef struct packed {
        logic          c2;
        logic          c3;
        logic          c3b;
        logic [OW-1:0] ofs;
    } comb_state_t;

    comb_state_t st_d, st_q;
    logic [SW-1:0] t_first, t_second, t_third, total;

    always_comb begin
        // Modular arithmetic; truncation yields two's complement.
        t_first  = SW'(carry[0]);
        t_second = SW'(carry[1]) - SW'(st_q.c2);
        t_third  = SW'(carry[2]) - (SW'(st_q.c3) << 1) + SW'(st_q.c3b);
        total    = t_first + t_second;
        if (order_sel == ORDER_3) begin
            total = total + t_third;
        end
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            st_d.c2  = carry[1];
            st_d.c3b = st_q.c3;
            st_d.c3  = carry[2];
            st_d.ofs = total[OW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign offset = st_q.ofs;

    assert_range_2nd_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(clr) && $past(order_sel) == ORDER_2) |->
        ($signed(offset) >= -4'sd1 && $signed(offset) <= 4'sd2));

    assert_range_3rd_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(clr) && $past(order_sel) == ORDER_3) |->
        ($signed(offset) >= -4'sd3 && $signed(offset) <= 4'sd4));

    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> (offset == '0));

endmodule

// File: rtl/mash_frac_mod.sv
`timescale 1ns/1ps
module mash_frac_mod
    import mash_pkg::*;
#(
    parameter int KW = 18,
    parameter int OW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [KW-1:0] frac_k,
    input  logic          lsb_dither_en,
    input  logic          order_sel,
    input  logic          int_force,
    output logic [OW-1:0] offset,
    output logic          int_mode
);

    localparam int AW = KW + 1;

    logic [AW-1:0]     word;
    logic              int_now;
    logic [AW-1:0]     chain [0:STAGES];
    logic [STAGES-1:0] carries;

    mash_word_ctrl #(.KW(KW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .frac_k    (frac_k),
        .dither_en (lsb_dither_en),
        .int_force (int_force),
        .word      (word),
        .int_now   (int_now),
        .int_flag  (int_mode)
    );

    assign chain[0] = word;

    // Stage g accumulates the fresh residue of stage g-1.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        mash_acc_stage #(.W(AW)) u_stage (
            .clk     (clk),
            .rst     (rst),
            .clr     (int_now),
            .addend  (chain[g]),
            .residue (chain[g+1]),
            .carry   (carries[g])
        );
    end

    mash_noise_combiner #(.OW(OW)) u_comb (
        .clk       (clk),
        .rst       (rst),
        .clr       (int_now),
        .order_sel (order_sel),
        .carry     (carries),
        .offset    (offset)
    );

    // From zero state, every stage holds the input word after one edge.
    assert_fresh_start_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(int_now) && !int_now) |-> (chain[STAGES] == word));

endmodule

// File: tb/mash_frac_mod_test.sv
`timescale 1ns/1ps
module mash_frac_mod_test;

    localparam int W = 19;
    localparam longint unsigned MOD = 64'd1 << W;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [17:0] frac_k = 18'd5;
    logic        lsb_dither_en = 1'b0;
    logic        order_sel = 1'b0;
    logic        int_force = 1'b0;
    logic [3:0]  offset;
    logic        int_mode;

    int errors = 0;
    int checks = 0;

    // Bench model state, written from the requirement equations.
    longint unsigned a1 = 0, a2 = 0, a3 = 0;
    int c2p = 0, c3p = 0, c3pp = 0;
    int exp_off = 0;
    int exp_flag = 1;
    longint unsigned cur_x = 0;

    longint run_t = 0, run_sum = 0;
    longint unsigned run_x = 0;

    always #10 clk = ~clk;

    mash_frac_mod uut (
        .clk           (clk),
        .rst           (rst),
        .frac_k        (frac_k),
        .lsb_dither_en (lsb_dither_en),
        .order_sel     (order_sel),
        .int_force     (int_force),
        .offset        (offset),
        .int_mode      (int_mode)
    );

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        a1 = 0; a2 = 0; a3 = 0;
        c2p = 0; c3p = 0; c3pp = 0;
        exp_off = 0;
        exp_flag = 1;
    endtask

    task automatic model_step(input logic [17:0] k, input bit rnd,
                              input bit ord, input bit frc);
        longint unsigned s;
        int c1, c2, c3;
        if (rst || frc || k == 0) begin
            model_clear();
        end else begin
            cur_x = (longint'(k) << 1) | longint'(rnd);
            s = a1 + cur_x;  c1 = int'(s >> W); a1 = s % MOD;
            s = a2 + a1;     c2 = int'(s >> W); a2 = s % MOD;
            s = a3 + a2;     c3 = int'(s >> W); a3 = s % MOD;
            exp_off = c1 + c2 - c2p;
            if (ord) exp_off = exp_off + c3 - 2 * c3p + c3pp;
            c2p = c2;
            c3pp = c3p;
            c3p = c3;
            exp_flag = 0;
        end
    endtask

    // Called at a falling edge: apply inputs, take one rising edge, check.
    task automatic drive(input logic [17:0] k, input bit rnd, input bit ord,
                         input bit frc, input string tag);
        string lab;
        int act;
        frac_k = k;
        lsb_dither_en = rnd;
        order_sel = ord;
        int_force = frc;
        model_step(k, rnd, ord, frc);
        @(posedge clk);
        @(negedge clk);
        act = int'($signed(offset));
        lab = ord ? "R4" : "R3";
        lab = {lab, " R2 R9 R11 offset ", tag};
        check_val(lab, act, exp_off);
        check_val({"R9 int_mode ", tag}, int'(int_mode), exp_flag);
        if (exp_flag != 0) begin
            run_t = 0;
            run_sum = 0;
        end else begin
            if (run_t == 0) run_x = cur_x;
            run_t++;
            run_sum += act;
        end
    endtask

    task automatic sum_check(input bit ord);
        longint lo, d;
        lo = longint'((longint'(run_t) * run_x) >> W);
        d = run_sum - lo;
        if (ord) check_val("R8 third-order running sum in bound",
                           int'(d >= -1 && d <= 2), 1);
        else     check_val("R8 second-order running sum in bound",
                           int'(d >= 0 && d <= 1), 1);
    endtask

    task automatic directed_run(input logic [17:0] k, input bit rnd, input bit ord,
                                input int len);
        drive(k, rnd, ord, 1'b1, "R7 clearing edge");
        for (int i = 0; i < len; i++) begin
            drive(k, rnd, ord, 1'b0, (i < 3) ? "R7 first edges after clear" : "run");
        end
        sum_check(ord);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);

        // R1: reset state
        repeat (3) @(negedge clk);
        model_clear();
        check_val("R1 reset offset", int'($signed(offset)), 0);
        check_val("R1 reset int_mode", int'(int_mode), 1);
        rst = 1'b0;

        // R6: zero word is integer mode even with dither set
        for (int i = 0; i < 4; i++) drive(18'd0, 1'b1, i[0], 1'b0, "R6 zero word");

        // R5: forced integer mode
        for (int i = 0; i < 4; i++) drive(18'h2AAAA, 1'b1, 1'b1, 1'b1, "R5 forced");

        // R7 and R8: long constant-word runs, including the extremes and the midpoint
        directed_run(18'd1,      1'b0, 1'b0, 4096);
        directed_run(18'd262143, 1'b1, 1'b0, 4096);
        directed_run(18'd131072, 1'b0, 1'b0, 4096);
        directed_run(18'd87381,  1'b1, 1'b0, 4096);
        directed_run(18'd200001, 1'b1, 1'b1, 4096);
        directed_run(18'd3,      1'b0, 1'b1, 4096);

        // Random segments; mid-segment order changes exercise R10
        for (int seg = 0; seg < 40; seg++) begin
            logic [17:0] k;
            bit rnd, ord, frc;
            int len;
            k = 18'($urandom);
            if (seg % 7 == 0) k = 18'd0;
            rnd = 1'($urandom);
            ord = 1'($urandom);
            frc = (($urandom % 6) == 0);
            len = 50 + int'($urandom % 100);
            for (int i = 0; i < len; i++) begin
                if (i == len / 2) ord = ~ord;
                drive(k, rnd, ord, frc,
                      (i >= len / 2) ? "R10 order changed mid-run" : "random");
            end
        end

        // R1: reset during operation
        drive(18'd77777, 1'b1, 1'b1, 1'b0, "before reset");
        rst = 1'b1;
        drive(18'd77777, 1'b1, 1'b1, 1'b0, "R1 reset mid-run");
        rst = 1'b0;
        for (int i = 0; i < 20; i++) drive(18'd77777, 1'b1, 1'b1, 1'b0, "R1 after reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule